// File: doc/BRIEF.md
# Banked Receive Mailbox Sequencer

This block holds received CAN frames in twelve mailboxes, grouped as three banks of four consecutive slots (0-3, 4-7, 8-11). A frame-write strobe deposits each incoming frame into the lowest-numbered slot that is armed and empty. Because hardware always picks the lowest free slot, arrival order would be lost if slots were re-armed one at a time. The block keeps the order by re-arming whole banks in rotation instead.

A consumer drains frames through a ready/valid pop port. Each pop returns the mailbox number, the stored identifier word, the decoded identifier, the extended and remote flags, the length code and 64 data bits. A slot that has been read stays disarmed, with its interrupt enable cleared, until its entire bank is recycled. Bank 2 acts as spill space, so that bank 0 can be given back late without reordering. The top slot, 11, is in overwrite mode: a frame arriving while it is still full replaces its contents and raises a one-cycle pulse.

Top module: `rx_bank_seq`

## Requirements
- R1: After reset the current bank is 0, all twelve armed bits are 1, pop_valid is 0 and ovwr_pulse is 0.
- R2: A strobed frame is stored in the lowest-numbered mailbox whose armed bit is 1 and which holds no unread frame; disarmed mailboxes are skipped.
- R3: A popped mailbox has its armed bit cleared on the next cycle and receives no frame until its bank is recycled.
- R4: With bank 0 current and armed bits 3:0 all zero, the current bank becomes 1 on the next cycle.
- R5: With bank 1 current and armed bits 7:4 all zero, bank 0 is re-armed and emptied and the current bank becomes 2 on the next cycle.
- R6: With bank 2 current and no unread frame in mailboxes 8-11, banks 1 and 2 are re-armed and emptied and the current bank becomes 0 on the next cycle; a frame strobed in that same cycle may already use the re-armed slots.
- R7: pop_valid offers the lowest-numbered mailbox holding an unread frame at or above the first mailbox of the current bank (bank number times 4); unread frames below that point wait.
- R8: Mailbox 11 accepts a frame while still full, replacing its contents; ovwr_pulse is 1 in the cycle after such a write and 0 after any other write.
- R9: A standard identifier (ext 0) is stored as its 11 bits shifted left by 18 with bit 29 clear; an extended identifier is stored in bits 28:0 with bit 29 set; pop_id returns the original identifier in either case.
- R10: The remote flag, length code and data bits of a popped frame equal those strobed in with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | One-cycle frame arrival strobe |
| wr_ext | input | 1 | Arriving frame uses a 29-bit identifier |
| wr_rtr | input | 1 | Arriving frame is a remote request |
| wr_id | input | 29 | Arriving identifier (11 LSBs used when standard) |
| wr_dlc | input | 4 | Arriving length code |
| wr_data | input | DATA_W | Arriving payload |
| pop_ready | input | 1 | Consumer accepts the offered frame |
| pop_valid | output | 1 | A frame is offered |
| pop_mb | output | clog2(3*BANK_W) | Mailbox number of the offered frame |
| pop_idword | output | 30 | Stored identifier word of the offered frame |
| pop_id | output | 29 | Decoded identifier |
| pop_ext | output | 1 | Extended identifier flag |
| pop_rtr | output | 1 | Remote request flag |
| pop_dlc | output | 4 | Length code |
| pop_data | output | DATA_W | Payload |
| ovwr_pulse | output | 1 | Mailbox 11 was overwritten on the previous edge |
| cur_bank | output | 2 | Bank the pop scan starts from |
| armed | output | 3*BANK_W | Per-mailbox receive and interrupt enable |

## Verification
Assertions check the bank rotation on every cycle: the step from bank 0 to 1, the re-arming of bank 0 on entering bank 2, the full re-arm on leaving bank 2, the disarming of a slot after it is read, and that the overwrite pulse only follows a strobe. Only the bench scenarios can show that frames leave in arrival order across a rotation, with spill frames in bank 2 served before newer frames in bank 0. The same applies to the identifier packing of both formats, the overwrite contents of slot 11, and a write that lands in a freshly re-armed slot on the very edge that leaves bank 2.

// File: rtl/rx_bank_seq.sv
module rx_bank_seq #(
  parameter int BANK_W = 4,
  parameter int DATA_W = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_stb,
  input  logic                          wr_ext,
  input  logic                          wr_rtr,
  input  logic [28:0]                   wr_id,
  input  logic [3:0]                    wr_dlc,
  input  logic [DATA_W-1:0]             wr_data,
  input  logic                          pop_ready,
  output logic                          pop_valid,
  output logic [$clog2(3*BANK_W)-1:0]   pop_mb,
  output logic [29:0]                   pop_idword,
  output logic [28:0]                   pop_id,
  output logic                          pop_ext,
  output logic                          pop_rtr,
  output logic [3:0]                    pop_dlc,
  output logic [DATA_W-1:0]             pop_data,
  output logic                          ovwr_pulse,
  output logic [1:0]                    cur_bank,
  output logic [3*BANK_W-1:0]           armed
);

  localparam int NMB  = 3 * BANK_W;
  localparam int MB_W = $clog2(NMB);
  localparam logic [NMB-1:0] M_B0  = {{(NMB-BANK_W){1'b0}}, {BANK_W{1'b1}}};
  localparam logic [NMB-1:0] M_B12 = ~M_B0;

  logic [NMB-1:0]    en_q, full_q, en_n, full_n;
  logic [NMB-1:0]    clr, eff_en, eff_full, avail;
  logic [1:0]        bank_q, bank_n;
  logic              ovwr_q;
  logic [29:0]       idw_q [NMB];
  logic              rtr_q [NMB];
  logic [3:0]        dlc_q [NMB];
  logic [DATA_W-1:0] dat_q [NMB];
  logic              wr_hit, pop_hit, do_pop, do_wr;
  logic [MB_W-1:0]   wt, pop_idx;
  logic [29:0]       wr_word;

  wire b0_idle = (en_q[BANK_W-1:0] == '0);
  wire b1_idle = (en_q[2*BANK_W-1:BANK_W] == '0);
  wire b2_done = (full_q[NMB-1:2*BANK_W] == '0);

  always_comb begin
    clr = '0;
    if (bank_q == 2'd1 && b1_idle) clr = M_B0;
    else if (bank_q == 2'd2 && b2_done) clr = M_B12;
  end

  assign eff_en   = en_q | clr;
  assign eff_full = full_q & ~clr;

  always_comb begin
    avail = eff_en & ~eff_full;
    avail[NMB-1] = eff_en[NMB-1];
    wr_hit = 1'b0;
    wt = '0;
    for (int i = NMB-1; i >= 0; i--)
      if (avail[i]) begin
        wr_hit = 1'b1;
        wt = MB_W'(i);
      end
  end

  always_comb begin
    pop_hit = 1'b0;
    pop_idx = '0;
    for (int i = NMB-1; i >= 0; i--)
      if (full_q[i] && i >= int'(bank_q) * BANK_W) begin
        pop_hit = 1'b1;
        pop_idx = MB_W'(i);
      end
  end

  always_comb begin
    case (bank_q)
      2'd0:    bank_n = b0_idle ? 2'd1 : 2'd0;
      2'd1:    bank_n = b1_idle ? 2'd2 : 2'd1;
      default: bank_n = b2_done ? 2'd0 : 2'd2;
    endcase
  end

  assign do_pop = pop_hit && pop_ready;
  assign do_wr  = wr_stb && wr_hit;

  always_comb begin
    en_n = eff_en;
    full_n = eff_full;
    if (do_pop) begin
      en_n[pop_idx] = 1'b0;
      full_n[pop_idx] = 1'b0;
    end
    if (do_wr) begin
      en_n[wt] = 1'b1;
      full_n[wt] = 1'b1;
    end
  end

  assign wr_word = wr_ext ? {1'b1, wr_id} : {1'b0, wr_id[10:0], 18'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '1;
      full_q <= '0;
      bank_q <= 2'd0;
      ovwr_q <= 1'b0;
    end else begin
      en_q   <= en_n;
      full_q <= full_n;
      bank_q <= bank_n;
      ovwr_q <= do_wr && (int'(wt) == NMB-1) && eff_full[NMB-1];
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) begin
      idw_q[wt] <= wr_word;
      rtr_q[wt] <= wr_rtr;
      dlc_q[wt] <= wr_dlc;
      dat_q[wt] <= wr_data;
    end
  end

  assign pop_valid  = pop_hit;
  assign pop_mb     = pop_idx;
  assign pop_idword = idw_q[pop_idx];
  assign pop_ext    = pop_idword[29];
  assign pop_id     = pop_ext ? pop_idword[28:0] : {18'b0, pop_idword[28:18]};
  assign pop_rtr    = rtr_q[pop_idx];
  assign pop_dlc    = dlc_q[pop_idx];
  assign pop_data   = dat_q[pop_idx];
  assign ovwr_pulse = ovwr_q;
  assign cur_bank   = bank_q;
  assign armed      = en_q;

  p_bank_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bank_q != 2'd3);

  p_read_disarms_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (do_pop && int'(pop_idx) != NMB-1) |=> !en_q[$past(pop_idx)]);

  p_b0_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_q == 2'd0 && en_q[BANK_W-1:0] == '0) |=> bank_q == 2'd1);

  p_b1_rearm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_q == 2'd1 && en_q[2*BANK_W-1:BANK_W] == '0)
      |=> (bank_q == 2'd2 && en_q[BANK_W-1:0] == '1));

  p_b2_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_q == 2'd2 && full_q[NMB-1:2*BANK_W] == '0)
      |=> (bank_q == 2'd0 && en_q == '1));

  p_ovwr_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovwr_q |-> $past(wr_stb));

endmodule

// File: tb/rx_bank_seq_bench.sv
`timescale 1ns/1ps
module rx_bank_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_stb = 1'b0, wr_ext = 1'b0, wr_rtr = 1'b0;
  logic [28:0] wr_id = '0;
  logic [3:0]  wr_dlc = '0;
  logic [63:0] wr_data = '0;
  logic        pop_ready = 1'b0;
  logic        pop_valid, pop_ext, pop_rtr, ovwr_pulse;
  logic [3:0]  pop_mb, pop_dlc;
  logic [29:0] pop_idword;
  logic [28:0] pop_id;
  logic [63:0] pop_data;
  logic [1:0]  cur_bank;
  logic [11:0] armed;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  rx_bank_seq u_rx_bank_seq (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_ext(wr_ext), .wr_rtr(wr_rtr),
    .wr_id(wr_id), .wr_dlc(wr_dlc), .wr_data(wr_data), .pop_ready(pop_ready),
    .pop_valid(pop_valid), .pop_mb(pop_mb), .pop_idword(pop_idword), .pop_id(pop_id),
    .pop_ext(pop_ext), .pop_rtr(pop_rtr), .pop_dlc(pop_dlc), .pop_data(pop_data),
    .ovwr_pulse(ovwr_pulse), .cur_bank(cur_bank), .armed(armed)
  );

  function automatic bit f_ext(int k); return k[0]; endfunction
  function automatic bit f_rtr(int k); return (k % 3) == 0; endfunction
  function automatic logic [3:0] f_dlc(int k); return 4'(k % 9); endfunction
  function automatic logic [28:0] f_id(int k);
    return f_ext(k) ? 29'(k * 1234567 + 11) : 29'((k * 97 + 5) % 2048);
  endfunction
  function automatic logic [29:0] f_word(int k);
    logic [28:0] id = f_id(k);
    return f_ext(k) ? {1'b1, id} : {1'b0, id[10:0], 18'b0};
  endfunction
  function automatic logic [63:0] f_data(int k);
    return {32'(k * 40503 + 7), 32'(k) ^ 32'h5a5a_0000};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int k, input bit exp_ovwr);
    wr_stb = 1'b1; wr_ext = f_ext(k); wr_rtr = f_rtr(k);
    wr_id = f_id(k); wr_dlc = f_dlc(k); wr_data = f_data(k);
    @(posedge clk); @(negedge clk);
    wr_stb = 1'b0;
    chk(ovwr_pulse == exp_ovwr, "R8 overwrite pulse", 128'(ovwr_pulse), 128'(exp_ovwr));
  endtask

  task automatic pexp(input int mb, input int k, input string tag);
    for (int w = 0; w < 8 && !pop_valid; w++) @(negedge clk);
    chk(pop_valid && pop_mb == 4'(mb), tag, {pop_valid, 3'b0, pop_mb}, {4'h1, 4'(mb)});
    chk(pop_idword == f_word(k) && pop_id == f_id(k) && pop_ext == f_ext(k),
        "R9 identifier packing", {pop_ext, pop_idword, 3'b0, pop_id}, {f_ext(k), f_word(k), 3'b0, f_id(k)});
    chk(pop_rtr == f_rtr(k) && pop_dlc == f_dlc(k) && pop_data == f_data(k),
        "R10 frame fields", {pop_rtr, pop_dlc, pop_data}, {f_rtr(k), f_dlc(k), f_data(k)});
    pop_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    pop_ready = 1'b0;
  endtask

  task automatic state(input logic [1:0] b, input logic [11:0] a, input string tag);
    chk(cur_bank == b && armed == a, tag, {cur_bank, armed}, {b, a});
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    state(2'd0, 12'hfff, "R1 reset bank and arm");
    chk(!pop_valid && !ovwr_pulse, "R1 reset outputs", {pop_valid, ovwr_pulse}, 2'b00);

    // Fill all twelve, then overwrite slot 11
    for (int k = 0; k < 12; k++) wr(k, 1'b0);
    wr(12, 1'b1);
    for (int m = 0; m < 4; m++) pexp(m, m, "R2 fill order");
    state(2'd0, 12'hff0, "R3 read slots disarmed");
    @(negedge clk);
    state(2'd1, 12'hff0, "R4 bank 0 to 1");
    for (int m = 4; m < 8; m++) pexp(m, m, "R7 scan from bank 1");
    @(negedge clk);
    state(2'd2, 12'hf0f, "R5 bank 0 re-armed, bank 2");
    for (int k = 40; k < 44; k++) wr(k, 1'b0);
    for (int m = 8; m < 11; m++) pexp(m, m, "R7 spill served first");
    pexp(11, 12, "R8 overwritten contents");
    wr(44, 1'b0);
    state(2'd0, 12'hfff, "R6 exit bank 2 rearm");
    for (int m = 0; m < 4; m++) pexp(m, 40 + m, "R7 bank 0 after spill");
    pexp(4, 44, "R6 write on exit edge");
    repeat (2) @(negedge clk);
    chk(!pop_valid, "R7 drained", 128'(pop_valid), 128'(0));

    // Disarmed slots skipped; lower frames wait while bank 2 is current
    do_reset();
    for (int k = 20; k < 24; k++) wr(k, 1'b0);
    for (int m = 0; m < 4; m++) pexp(m, 20 + m, "R2 second fill");
    @(negedge clk);
    state(2'd1, 12'hff0, "R4 second rotation");
    for (int k = 24; k < 29; k++) wr(k, 1'b0);
    for (int m = 4; m < 8; m++) pexp(m, 20 + m, "R3 read slots not reused");
    @(negedge clk);
    state(2'd2, 12'hf0f, "R5 second rotation");
    wr(29, 1'b0);
    pexp(8, 28, "R7 mailbox 0 waits behind bank 2");
    @(negedge clk);
    state(2'd0, 12'hfff, "R6 second exit");
    pexp(0, 29, "R2 frame went to mailbox 0");

    // Repeated overwrite of slot 11 keeps only the newest frame
    do_reset();
    for (int k = 50; k < 62; k++) wr(k, 1'b0);
    for (int k = 62; k < 65; k++) wr(k, 1'b1);
    for (int m = 0; m < 11; m++) pexp(m, 50 + m, "R2 third fill");
    pexp(11, 64, "R8 newest overwrite kept");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule